// File: doc/BRIEF.md
# Supervisor Status and Trap Unit

This block holds the processor's supervisor status word and decides, once per cycle, whether a trap is entered. It receives a vector of pending interrupt lines, a synchronous exception request with its cause code, and a register write and read port for the status word. When a trap is entered, it emits a one-cycle strobe with the cause word and a fetch redirect to the trap vector. In the same clock edge it updates the status word: traps are disabled, supervisor mode is entered, and the mode held before the trap is saved.

From the status word the block drives the current privilege, the saved previous privilege, the active integer width and the virtual-memory enable. Every status write or trap entry updates these outputs on the next cycle. After reset, a one-cycle redirect sends fetch to the boot address. Return from trap is handled elsewhere, which is why the saved previous-privilege bit is exposed as an output.

Status word layout, with the remaining bits reserved and always zero:

| Bit | Meaning |
|-----|---------|
| 0 | trap enable |
| 1 | supervisor |
| 2 | previous supervisor |
| 3 | 64-bit flag for supervisor mode |
| 4 | 64-bit flag for user mode |
| 5 | VM enable |
| 8 and up (`NUM_IRQ` bits) | interrupt mask |

The read port selects the status word with `rd_sel` = 0 and the last cause with `rd_sel` = 1. Any other select value reads zero.

Top module: `sup_status_unit`

## Requirements
- R1: After reset, the status reads supervisor=1, supervisor 64-bit flag=1 (0 when 64-bit support is off) and all mask bits=1, with every other bit 0. With 8 lines and 64-bit support on, the value is 0xFF0A. In the first cycle after reset, `redirect_valid`=1 with `redirect_pc`=`RESET_PC` (0x2000). In the next cycle `redirect_valid` is 0.
- R2: Pending line i can cause a trap only while mask bit 8+i is 1 and the trap-enable bit is 1.
- R3: When several pending lines are unmasked, the lowest-numbered one is taken.
- R4: An interrupt cause word has bit XLEN-1 set and the line number in its low bits. An exception cause word is the exception code zero-extended, so bit XLEN-1 is clear. The cause word is also readable with `rd_sel`=1.
- R5: On trap entry, trap enable becomes 0 and supervisor becomes 1. Previous supervisor takes the supervisor value held before the trap.
- R6: A status write stores only the defined bits (0–5 and the mask field), and every reserved bit reads 0. With 64-bit support off, both 64-bit flags read 0 after any write.
- R7: `xlen64` is the supervisor 64-bit flag in supervisor mode and the user 64-bit flag in user mode.
- R8: `vm_enable` and `priv_sup` reflect a status write in the cycle after the write.
- R9: A synchronous exception is taken regardless of trap enable. It wins over any interrupt requested in the same cycle.
- R10: `trap_taken` rises in the cycle after the request, lasts one cycle per request, and comes with `redirect_valid`=1 and `redirect_pc`=`TRAP_VEC`.
- R11: When a trap and a status write fall in the same cycle, the trap update is applied to the old status and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| irq_pending | input | NUM_IRQ | pending interrupt lines |
| exc_req | input | 1 | synchronous exception request |
| exc_code | input | CAUSE_W | exception cause code |
| sr_wr_en | input | 1 | status write strobe |
| sr_wr_data | input | XLEN | status write value |
| rd_sel | input | 2 | read select: 0 status, 1 cause |
| rd_data | output | XLEN | read data |
| trap_taken | output | 1 | trap entry strobe |
| trap_cause | output | XLEN | cause word of the last trap |
| redirect_valid | output | 1 | fetch redirect request |
| redirect_pc | output | XLEN | fetch redirect target |
| priv_sup | output | 1 | current supervisor mode |
| prev_sup | output | 1 | saved previous supervisor mode |
| xlen64 | output | 1 | active integer width is 64 |
| vm_enable | output | 1 | virtual memory enable |

## Verification
The interrupt decision is driven from a table of status words and pending patterns:

- several unmasked lines at once, which shows whether the lowest one is chosen;
- only masked lines, which shows whether the mask is applied;
- lines pending with trap enable clear, which shows whether the enable gates interrupts;
- entry from both user and supervisor mode, which shows whether the previous-mode bit saves the old mode rather than a constant.

Directed cases then cover the remaining orderings: an exception against an interrupt in the same cycle, an exception with traps disabled, and a write colliding with a trap. A second instance with 64-bit support off shows that the width flags are forced to zero.

// File: rtl/sst_pkg.sv
// Package: field positions of the supervisor status word and read selects.
// Assumes the interrupt mask field starts at IM_LSB and fits below XLEN-1.
package sst_pkg;
    localparam int TE_BIT   = 0;
    localparam int SUP_BIT  = 1;
    localparam int PSUP_BIT = 2;
    localparam int WS_BIT   = 3;
    localparam int WU_BIT   = 4;
    localparam int VM_BIT   = 5;
    localparam int IM_LSB   = 8;

    typedef enum logic [1:0] {
        RD_STATUS = 2'd0,
        RD_CAUSE  = 2'd1
    } rd_sel_e;
endpackage

// File: rtl/sst_irq_pick.sv
// Module: lowest-index priority picker over a pending vector.
// Assumes N >= 2; idx is meaningful only when any is high.
module sst_irq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Flag that some request is present.
    assign any = |req;
endmodule

// File: rtl/sst_status_reg.sv
// Module: holds the status word; applies trap-entry updates or masked writes.
// Assumes a trap in the same cycle as a write takes precedence.
module sst_status_reg #(
    parameter int XLEN     = 64,
    parameter int NUM_IRQ  = 8,
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_take,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] sr_q
);
    import sst_pkg::*;

    localparam logic [XLEN-1:0] IM_FIELD =
        {{(XLEN-NUM_IRQ){1'b0}}, {NUM_IRQ{1'b1}}} << IM_LSB;
    localparam logic [XLEN-1:0] WIDE_BITS = HAS_WIDE ?
        ((XLEN'(1) << WS_BIT) | (XLEN'(1) << WU_BIT)) : '0;
    localparam logic [XLEN-1:0] BASE_BITS =
        (XLEN'(1) << TE_BIT) | (XLEN'(1) << SUP_BIT) |
        (XLEN'(1) << PSUP_BIT) | (XLEN'(1) << VM_BIT);
    localparam logic [XLEN-1:0] WMASK = BASE_BITS | WIDE_BITS | IM_FIELD;
    localparam logic [XLEN-1:0] RST_SR = IM_FIELD | (XLEN'(1) << SUP_BIT) |
        (HAS_WIDE ? (XLEN'(1) << WS_BIT) : '0);

    logic [XLEN-1:0] sr_next;

    // Next status: trap entry first, then a masked software write.
    always_comb begin
        sr_next = sr_q;
        if (trap_take) begin
            sr_next[TE_BIT]   = 1'b0;
            sr_next[PSUP_BIT] = sr_q[SUP_BIT];
            sr_next[SUP_BIT]  = 1'b1;
        end else if (wr_en) begin
            sr_next = wr_data & WMASK;
        end
    end

    // Status register with synchronous reset to boot state.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= RST_SR;
        else        sr_q <= sr_next;
    end
endmodule

// File: rtl/sst_trap_ctrl.sv
// Module: decides trap entry, forms the cause word, registers strobe and redirect.
// Assumes exceptions ignore trap enable and outrank interrupts.
module sst_trap_ctrl #(
    parameter int              XLEN     = 64,
    parameter int              NUM_IRQ  = 8,
    parameter int              CAUSE_W  = 6,
    parameter logic [XLEN-1:0] RESET_PC = 64'h2000,
    parameter logic [XLEN-1:0] TRAP_VEC = 64'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               te,
    input  logic [NUM_IRQ-1:0] imask,
    input  logic [NUM_IRQ-1:0] irq_pending,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_code,
    output logic               take,
    output logic               trap_taken,
    output logic [XLEN-1:0]    trap_cause,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic             irq_any;
    logic [IDX_W-1:0] irq_idx;
    logic             irq_take;
    logic [XLEN-1:0]  cause_next;
    logic             trap_q;
    logic             boot_q;

    sst_irq_pick #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
        .req (irq_pending & imask),
        .any (irq_any),
        .idx (irq_idx)
    );

    // Interrupts need trap enable; exceptions always enter.
    assign irq_take = irq_any && te;
    assign take     = exc_req || irq_take;

    // Cause word: exception code, else flagged interrupt number.
    always_comb begin
        if (exc_req) cause_next = XLEN'(exc_code);
        else         cause_next = {1'b1, (XLEN-1)'(irq_idx)};
    end

    // Strobe and cause registers; cause holds until the next trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q     <= 1'b0;
            trap_cause <= '0;
        end else begin
            trap_q <= take;
            if (take) trap_cause <= cause_next;
        end
    end

    // One-cycle boot redirect after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= 1'b0;
    end

    assign trap_taken     = trap_q;
    assign redirect_valid = trap_q || boot_q;
    assign redirect_pc    = boot_q ? RESET_PC : TRAP_VEC;
endmodule

// File: rtl/sup_status_unit.sv
// Module: top of the supervisor status and trap unit.
// Assumes NUM_IRQ + 8 < XLEN and CAUSE_W < XLEN.
module sup_status_unit #(
    parameter int              XLEN     = 64,
    parameter int              NUM_IRQ  = 8,
    parameter int              CAUSE_W  = 6,
    parameter bit              HAS_WIDE = 1'b1,
    parameter logic [XLEN-1:0] RESET_PC = 64'h2000,
    parameter logic [XLEN-1:0] TRAP_VEC = 64'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pending,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_code,
    input  logic               sr_wr_en,
    input  logic [XLEN-1:0]    sr_wr_data,
    input  logic [1:0]         rd_sel,
    output logic [XLEN-1:0]    rd_data,
    output logic               trap_taken,
    output logic [XLEN-1:0]    trap_cause,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               priv_sup,
    output logic               prev_sup,
    output logic               xlen64,
    output logic               vm_enable
);
    import sst_pkg::*;

    logic [XLEN-1:0] sr_q;
    logic            take;

    sst_status_reg #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .HAS_WIDE(HAS_WIDE)) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_take (take),
        .wr_en     (sr_wr_en),
        .wr_data   (sr_wr_data),
        .sr_q      (sr_q)
    );

    sst_trap_ctrl #(
        .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W),
        .RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC)
    ) u_trap (
        .clk            (clk),
        .rst_n          (rst_n),
        .te             (sr_q[TE_BIT]),
        .imask          (sr_q[IM_LSB +: NUM_IRQ]),
        .irq_pending    (irq_pending),
        .exc_req        (exc_req),
        .exc_code       (exc_code),
        .take           (take),
        .trap_taken     (trap_taken),
        .trap_cause     (trap_cause),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    // Mode outputs decoded from the held status word.
    assign priv_sup  = sr_q[SUP_BIT];
    assign prev_sup  = sr_q[PSUP_BIT];
    assign vm_enable = sr_q[VM_BIT];
    assign xlen64    = sr_q[SUP_BIT] ? sr_q[WS_BIT] : sr_q[WU_BIT];

    // Read mux for status and cause.
    always_comb begin
        case (rd_sel)
            RD_STATUS: rd_data = sr_q;
            RD_CAUSE:  rd_data = trap_cause;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sst_checker.sv
// Module: property checker for sup_status_unit, attached by bind.
// Assumes it sees the held status word of the unit.
module sst_checker #(
    parameter int XLEN     = 64,
    parameter int NUM_IRQ  = 8,
    parameter bit HAS_WIDE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_pending,
    input logic               exc_req,
    input logic [XLEN-1:0]    sr_q,
    input logic               trap_taken,
    input logic [XLEN-1:0]    trap_cause,
    input logic               priv_sup,
    input logic               prev_sup,
    input logic               xlen64
);
    import sst_pkg::*;

    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [XLEN-1:0] DEF_BITS =
        ({{(XLEN-NUM_IRQ){1'b0}}, {NUM_IRQ{1'b1}}} << IM_LSB) | XLEN'(8'h3F);

    logic [NUM_IRQ-1:0] live_q;
    logic [NUM_IRQ-1:0] below;
    logic [IDX_W-1:0]   cidx;

    // Remember last cycle's unmasked pending lines.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= irq_pending & sr_q[IM_LSB +: NUM_IRQ];
    end

    assign cidx  = trap_cause[IDX_W-1:0];
    assign below = (NUM_IRQ'(1) << cidx) - NUM_IRQ'(1);

    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> priv_sup && !sr_q[TE_BIT]); // R5
    AST_PREV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> prev_sup == $past(priv_sup)); // R5
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_cause[XLEN-1]) |-> $past(sr_q[TE_BIT])); // R2
    AST_IRQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_cause[XLEN-1]) |-> (live_q[cidx] && ((live_q & below) == '0))); // R3
    AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req)) |-> (trap_taken && !trap_cause[XLEN-1])); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q & ~DEF_BITS) == '0); // R6
    AST_NARROW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_WIDE |-> !xlen64); // R6
endmodule

bind sup_status_unit sst_checker #(
    .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .HAS_WIDE(HAS_WIDE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pending (irq_pending),
    .exc_req     (exc_req),
    .sr_q        (sr_q),
    .trap_taken  (trap_taken),
    .trap_cause  (trap_cause),
    .priv_sup    (priv_sup),
    .prev_sup    (prev_sup),
    .xlen64      (xlen64)
);

// File: tb/sup_status_unit_bench.sv
module sup_status_unit_bench;
    localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;
    localparam int          NV   = 8;

    // status written, pending lines, expected winner (4'hF = none)
    localparam logic [15:0] V_SR   [NV] = '{16'hFF01, 16'hFF01, 16'hF001, 16'hF001,
                                            16'hFF00, 16'h0003, 16'h0101, 16'hFF03};
    localparam logic [7:0]  V_PEND [NV] = '{8'h0C, 8'h80, 8'h0F, 8'h3F,
                                            8'hFF, 8'h01, 8'h01, 8'h10};
    localparam logic [3:0]  V_IDX  [NV] = '{4'd2, 4'd7, 4'hF, 4'd4,
                                            4'hF, 4'hF, 4'd0, 4'd4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pending = '0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_code = '0;
    logic        sr_wr_en = 1'b0;
    logic [63:0] sr_wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data, trap_cause, redirect_pc;
    logic        trap_taken, redirect_valid, priv_sup, prev_sup, xlen64, vm_enable;

    logic        n_wr_en = 1'b0;
    logic [63:0] n_rd_data, n_cause, n_rpc;
    logic        n_tt, n_rv, n_ps, n_pps, n_x64, n_vm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sup_status_unit u_sup_status_unit (
        .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .exc_req(exc_req),
        .exc_code(exc_code), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .trap_taken(trap_taken),
        .trap_cause(trap_cause), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv_sup(priv_sup), .prev_sup(prev_sup),
        .xlen64(xlen64), .vm_enable(vm_enable)
    );

    sup_status_unit #(.HAS_WIDE(1'b0)) u_narrow (
        .clk(clk), .rst_n(rst_n), .irq_pending(8'h00), .exc_req(1'b0),
        .exc_code(6'd0), .sr_wr_en(n_wr_en), .sr_wr_data(sr_wr_data),
        .rd_sel(2'd0), .rd_data(n_rd_data), .trap_taken(n_tt),
        .trap_cause(n_cause), .redirect_valid(n_rv), .redirect_pc(n_rpc),
        .priv_sup(n_ps), .prev_sup(n_pps), .xlen64(n_x64), .vm_enable(n_vm)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_sr(input logic [63:0] v);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: values visible before the first post-reset edge
        rd_sel = 2'd0; #1;
        check("R1 status", rd_data, 64'hFF0A);
        check("R1 redirect_valid", 64'(redirect_valid), 64'd1);
        check("R1 redirect_pc", redirect_pc, 64'h2000);
        check("R1 xlen64", 64'(xlen64), 64'd1);
        check("R1 vm_enable", 64'(vm_enable), 64'd0);
        check("R1 trap_taken", 64'(trap_taken), 64'd0);
        check("R1 narrow status", n_rd_data, 64'hFF02);
        @(negedge clk);
        check("R1 redirect drops", 64'(redirect_valid), 64'd0);

        // Table: R2 gate/mask, R3 lowest, R4 cause, R5 entry update
        for (int i = 0; i < NV; i++) begin
            automatic bit tk = (V_IDX[i] != 4'hF);
            write_sr(64'(V_SR[i]));
            irq_pending = V_PEND[i];
            @(negedge clk);
            irq_pending = '0;
            check($sformatf("R2 taken v%0d", i), 64'(trap_taken), 64'(tk));
            if (tk) begin
                check($sformatf("R3 R4 cause v%0d", i), trap_cause, MSB | 64'(V_IDX[i]));
                check($sformatf("R5 prev_sup v%0d", i), 64'(prev_sup), 64'(V_SR[i][1]));
                check($sformatf("R5 sup v%0d", i), 64'(priv_sup), 64'd1);
                check($sformatf("R5 te v%0d", i), 64'(rd_data[0]), 64'd0);
                check($sformatf("R10 redirect v%0d", i), redirect_pc, 64'h100);
            end else begin
                check($sformatf("R2 status kept v%0d", i), rd_data, 64'(V_SR[i]));
            end
            @(negedge clk);
            check($sformatf("R10 one pulse v%0d", i), 64'(trap_taken), 64'd0);
        end

        // R6: reserved bits and narrow config
        @(negedge clk);
        sr_wr_en = 1'b1; n_wr_en = 1'b1; sr_wr_data = '1;
        @(negedge clk);
        sr_wr_en = 1'b0; n_wr_en = 1'b0;
        check("R6 reserved zero", rd_data, 64'hFF3F);
        check("R6 narrow flags", n_rd_data, 64'hFF27);
        check("R6 narrow xlen64", 64'(n_x64), 64'd0);

        // R7: width per mode
        write_sr(64'h12); check("R7 sup uses WS", 64'(xlen64), 64'd0);
        write_sr(64'h10); check("R7 user uses WU", 64'(xlen64), 64'd1);
        write_sr(64'h08); check("R7 user ignores WS", 64'(xlen64), 64'd0);
        write_sr(64'h0A); check("R7 sup WS", 64'(xlen64), 64'd1);

        // R8: vm and privilege follow a write
        write_sr(64'h20);
        check("R8 vm on", 64'(vm_enable), 64'd1);
        check("R8 user", 64'(priv_sup), 64'd0);
        write_sr(64'h02);
        check("R8 vm off", 64'(vm_enable), 64'd0);
        check("R8 sup", 64'(priv_sup), 64'd1);

        // R9: exception beats interrupt in the same cycle
        write_sr(64'hFF01);
        irq_pending = 8'h01; exc_req = 1'b1; exc_code = 6'h11;
        @(negedge clk);
        irq_pending = '0; exc_req = 1'b0;
        check("R9 exc wins taken", 64'(trap_taken), 64'd1);
        check("R9 exc wins cause", trap_cause, 64'h11);
        rd_sel = 2'd1; #1;
        check("R4 cause readable", rd_data, 64'h11);
        rd_sel = 2'd0;
        // R9: exception with traps disabled (status now 0xFF02)
        exc_req = 1'b1; exc_code = 6'h03;
        @(negedge clk);
        exc_req = 1'b0;
        check("R9 exc with TE=0", 64'(trap_taken), 64'd1);
        check("R9 exc cause", trap_cause, 64'h03);
        check("R5 prev_sup from sup", 64'(prev_sup), 64'd1);

        // R11: trap and write collide
        write_sr(64'hFF01);
        sr_wr_en = 1'b1; sr_wr_data = 64'h20; exc_req = 1'b1; exc_code = 6'h05;
        @(negedge clk);
        sr_wr_en = 1'b0; exc_req = 1'b0;
        check("R11 trap over write", rd_data, 64'hFF02);
        check("R11 vm unchanged", 64'(vm_enable), 64'd0);
        check("R10 strobe", 64'(trap_taken), 64'd1);
        check("R10 redirect_valid", 64'(redirect_valid), 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule